// File: doc/BRIEF.md
# Externally Steered SRAM Self-Test Engine

This block runs a built-in self-test on one single-port SRAM without holding any test algorithm of its own. An outside sequencer steers it cycle by cycle through three small inputs. A two-bit address control picks whether the address moves and in which direction. A polarity bit picks an all-zeros or all-ones data word. A write bit picks a write or a read. From these inputs the engine drives the memory's address, write enable and write data. Any march test can therefore be played through it by changing only the control stream.

On each read the engine remembers the polarity that was in force and compares it with the word the memory returns one cycle later. It counts every bit that differs, not only every failing read, in a saturating counter. A sticky flag records that at least one mismatch has been seen. A one-cycle pulse marks the end of each full address sweep. After a completed sweep the address returns to the starting location for whatever direction is requested next, so a descending element starts at the top location.

Top module: `sram_sweep_bist`

## Requirements
- R1: With `ctl_addr` = 2'b10 (bit 1 = move, bit 0 = 0 for upward), `mem_addr` rises by one at each clock edge.
- R2: With `ctl_addr` = 2'b11, `mem_addr` falls by one at each clock edge.
- R3: With `ctl_addr[1]` = 0, `mem_addr` keeps its value across the clock edge.
- R4: After reset, and after a completed sweep, `mem_addr` shows location 0 when `ctl_addr[0]` = 0 and location DEPTH-1 when `ctl_addr[0]` = 1.
- R5: A move issued at the last location of the current direction (DEPTH-1 going up, 0 going down) completes a sweep. `sweep_end` is then high for exactly the one cycle after that edge and low at all other times.
- R6: In the same cycle, `mem_we` equals `ctl_wr`, and `mem_wdata` is all ones when `ctl_pol` = 1 and all zeros when `ctl_pol` = 0.
- R7: For a read issued in cycle n, `mem_rdata` in cycle n+1 is compared bit by bit with the cycle-n polarity word. The number of differing bits is added to `fail_total`, which shows the new value after the edge that ends cycle n+1.
- R8: Write cycles add nothing to `fail_total`, whatever `mem_rdata` carries in the following cycle.
- R9: `fail_seen` rises together with the first nonzero addition to `fail_total` and stays high until reset.
- R10: `fail_total` saturates at 2^FAIL_W-1 and does not wrap.
- R11: A synchronous reset (`rst` high at an edge) clears `fail_total`, `fail_seen` and `sweep_end`, and discards any read still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_addr | input | 2 | Bit 1: move the address; bit 0: 1 = downward, 0 = upward |
| ctl_pol | input | 1 | Data polarity: 1 = all ones, 0 = all zeros |
| ctl_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | $clog2(DEPTH) | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | WIDTH | Memory write data |
| mem_rdata | input | WIDTH | Memory read data, one cycle after the read |
| sweep_end | output | 1 | One-cycle pulse after a full sweep |
| fail_seen | output | 1 | Sticky mismatch flag |
| fail_total | output | FAIL_W | Saturating count of mismatching bits |

## Verification
The address, write enable and write data follow the control inputs in the same cycle. The bench therefore drives the controls after the falling edge and checks these outputs 1 ns later, before the next rising edge. `sweep_end` appears one edge after the final move. A read's contribution to `fail_total` and `fail_seen` appears two edges after the read is issued: one edge for the memory latency and one for the accumulator. The bench's reference model keeps a pending-read slot so that each expected count becomes visible at exactly that point, and every output is compared with the model in every cycle. Random control streams and random read-data corruption are mixed with directed march sweeps, a write-only window with corrupted data, a saturation run, and resets in both directions.

// File: rtl/sweep_bist_pkg.sv
package sweep_bist_pkg;
  // direction encoding of ctl_addr[0]
  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/sweep_bist_addr.sv
module sweep_bist_addr
  import sweep_bist_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  sweep_dir_e    dir_i,
  output logic [AW-1:0] addr_o,
  output logic          wrap_hit_o,
  output logic          sweep_end_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          fresh_q;
  logic          end_q;

  function automatic logic [AW-1:0] start_of(input sweep_dir_e d);
    return (d == SWEEP_DOWN) ? TOP : '0;
  endfunction

  function automatic logic [AW-1:0] last_of(input sweep_dir_e d);
    return (d == SWEEP_DOWN) ? '0 : TOP;
  endfunction

  function automatic logic [AW-1:0] next_of(input logic [AW-1:0] a, input sweep_dir_e d);
    return (d == SWEEP_DOWN) ? a - 1'b1 : a + 1'b1;
  endfunction

  assign addr_o      = fresh_q ? start_of(dir_i) : addr_q;
  assign wrap_hit_o  = step_i && (addr_o == last_of(dir_i));
  assign sweep_end_o = end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      fresh_q <= 1'b1;
      end_q   <= 1'b0;
    end else begin
      end_q <= wrap_hit_o;
      if (step_i) begin
        if (wrap_hit_o) begin
          fresh_q <= 1'b1;
        end else begin
          fresh_q <= 1'b0;
          addr_q  <= next_of(addr_o, dir_i);
        end
      end
    end
  end

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i) |=> (addr_q == $past(addr_q)));

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_i == SWEEP_UP && !wrap_hit_o) |=> (addr_q == $past(addr_o) + 1'b1));

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_i == SWEEP_DOWN && !wrap_hit_o) |=> (addr_q == $past(addr_o) - 1'b1));

  // R5
  end_follows_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_hit_o |=> end_q);
endmodule

// File: rtl/sweep_bist_cmp.sv
module sweep_bist_cmp #(
  parameter int WIDTH = 32,
  parameter int CW    = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_issue_i,
  input  logic             pol_i,
  input  logic [WIDTH-1:0] rdata_i,
  output logic             valid_o,
  output logic [CW-1:0]    miss_o
);
  logic [WIDTH-1:0] exp_q;
  logic             vld_q;
  logic [WIDTH-1:0] diff;

  function automatic logic [CW-1:0] ones_in(input logic [WIDTH-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < WIDTH; i++) begin
      n = n + CW'(v[i]);
    end
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      exp_q <= '0;
    end else begin
      vld_q <= rd_issue_i;
      exp_q <= {WIDTH{pol_i}};
    end
  end

  assign diff    = rdata_i ^ exp_q;
  assign valid_o = vld_q;
  assign miss_o  = vld_q ? ones_in(diff) : '0;

  // R8
  write_no_compare_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_issue_i) |=> (!valid_o));

  // R7
  miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
    miss_o <= CW'(WIDTH));
endmodule

// File: rtl/sweep_bist_acc.sv
module sweep_bist_acc #(
  parameter int CW     = 6,
  parameter int FAIL_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [CW-1:0]     miss_i,
  output logic [FAIL_W-1:0] total_o,
  output logic              seen_o
);
  localparam int SW = FAIL_W + CW;
  localparam logic [FAIL_W-1:0] MAXC = {FAIL_W{1'b1}};

  logic [FAIL_W-1:0] total_q;
  logic              seen_q;

  function automatic logic [FAIL_W-1:0] sat_add(input logic [FAIL_W-1:0] a,
                                                input logic [CW-1:0] b);
    logic [SW-1:0] s;
    s = SW'(a) + SW'(b);
    return (s > SW'(MAXC)) ? MAXC : s[FAIL_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      seen_q  <= 1'b0;
    end else if (valid_i) begin
      total_q <= sat_add(total_q, miss_i);
      if (miss_i != '0) seen_q <= 1'b1;
    end
  end

  assign total_o = total_q;
  assign seen_o  = seen_q;

  // R9
  seen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |=> seen_q);

  // R8
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_i) |=> (total_q == $past(total_q)));

  // R10
  saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (total_q == MAXC) |=> (total_q == MAXC));

  // R7
  no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (total_q >= $past(total_q)));
endmodule

// File: rtl/sram_sweep_bist.sv
module sram_sweep_bist
  import sweep_bist_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 32,
  parameter int FAIL_W = $clog2(DEPTH * WIDTH) + 5,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ctl_addr,
  input  logic              ctl_pol,
  input  logic              ctl_wr,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [WIDTH-1:0]  mem_wdata,
  input  logic [WIDTH-1:0]  mem_rdata,
  output logic              sweep_end,
  output logic              fail_seen,
  output logic [FAIL_W-1:0] fail_total
);
  localparam int CW = $clog2(WIDTH + 1);

  logic          step;
  sweep_dir_e    dir;
  logic          wrap_hit;
  logic          cmp_valid;
  logic [CW-1:0] miss_bits;

  assign step      = ctl_addr[1];
  assign dir       = sweep_dir_e'(ctl_addr[0]);
  assign mem_we    = ctl_wr;
  assign mem_wdata = {WIDTH{ctl_pol}};

  sweep_bist_addr #(.DEPTH(DEPTH), .AW(AW)) addr_u (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step),
    .dir_i       (dir),
    .addr_o      (mem_addr),
    .wrap_hit_o  (wrap_hit),
    .sweep_end_o (sweep_end)
  );

  sweep_bist_cmp #(.WIDTH(WIDTH), .CW(CW)) cmp_u (
    .clk        (clk),
    .rst        (rst),
    .rd_issue_i (!ctl_wr),
    .pol_i      (ctl_pol),
    .rdata_i    (mem_rdata),
    .valid_o    (cmp_valid),
    .miss_o     (miss_bits)
  );

  sweep_bist_acc #(.CW(CW), .FAIL_W(FAIL_W)) acc_u (
    .clk     (clk),
    .rst     (rst),
    .valid_i (cmp_valid),
    .miss_i  (miss_bits),
    .total_o (fail_total),
    .seen_o  (fail_seen)
  );

  // R5
  end_single_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_end |=> !sweep_end);

  // R9
  seen_with_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_seen) |-> (fail_total != '0));
endmodule

// File: tb/sram_sweep_bist_tb_top.sv
`timescale 1ns/1ps
module sram_sweep_bist_tb_top;
  localparam int DEPTH  = 16;
  localparam int WIDTH  = 8;
  localparam int FAIL_W = 10;
  localparam int AW     = $clog2(DEPTH);
  localparam int MAXC   = (1 << FAIL_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        c_addr = 2'b00;
  logic              c_pol = 1'b0;
  logic              c_wr = 1'b1;
  logic [AW-1:0]     mem_addr;
  logic              mem_we;
  logic [WIDTH-1:0]  mem_wdata;
  logic [WIDTH-1:0]  mem_rdata = '0;
  logic              sweep_end;
  logic              fail_seen;
  logic [FAIL_W-1:0] fail_total;

  logic [WIDTH-1:0]  ram [DEPTH];
  logic [WIDTH-1:0]  inj = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  // reference model state
  int             m_addr;
  bit             m_fresh;
  bit             m_end;
  bit             m_fail;
  int             m_cnt;
  bit             m_pv;
  logic [WIDTH-1:0] m_pe;
  logic [WIDTH-1:0] m_pd;

  always #2.5 clk = ~clk;

  sram_sweep_bist #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FAIL_W(FAIL_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .ctl_addr   (c_addr),
    .ctl_pol    (c_pol),
    .ctl_wr     (c_wr),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .sweep_end  (sweep_end),
    .fail_seen  (fail_seen),
    .fail_total (fail_total)
  );

  // memory model: synchronous write, one-cycle read with optional corruption
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr] ^ inj;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int model_sat(input int a, input int b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  task automatic do_reset(input logic dir);
    rst = 1'b1;
    c_addr = {1'b0, dir};
    c_wr = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_fresh = 1'b1; m_addr = 0; m_end = 1'b0; m_fail = 1'b0;
    m_cnt = 0; m_pv = 1'b0;
    #1;
    check("R11 total", fail_total, 0);
    check("R11 seen", fail_seen, 0);
    check("R11 end", sweep_end, 0);
    check("R4 start", mem_addr, dir ? DEPTH - 1 : 0);
  endtask

  // one steered cycle: drive, check against model, advance model
  task automatic run(input logic [1:0] a, input logic p, input logic w);
    int    eff;
    int    last;
    string tag;
    c_addr = a; c_pol = p; c_wr = w;
    #1;
    eff = m_fresh ? (a[0] ? DEPTH - 1 : 0) : m_addr;
    if (m_fresh) tag = "R4";
    else if (!a[1]) tag = "R3";
    else if (a[0]) tag = "R2";
    else tag = "R1";
    check(tag, mem_addr, eff);
    check("R6 we", mem_we, w);
    check("R6 data", mem_wdata, p ? {WIDTH{1'b1}} : {WIDTH{1'b0}});
    check("R5", sweep_end, m_end);
    check("R9", fail_seen, m_fail);
    check((m_cnt == MAXC) ? "R10" : "R7", fail_total, m_cnt);
    // retire the pending read
    if (m_pv) begin
      int mm;
      mm = $countones(m_pd ^ m_pe);
      m_cnt = model_sat(m_cnt, mm);
      if (mm != 0) m_fail = 1'b1;
    end
    m_pv = !w;
    m_pe = p ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
    m_pd = ram[eff] ^ inj;
    // address model
    m_end = 1'b0;
    if (a[1]) begin
      last = a[0] ? 0 : DEPTH - 1;
      if (eff == last) begin
        m_fresh = 1'b1;
        m_end = 1'b1;
      end else begin
        m_fresh = 1'b0;
        m_addr = a[0] ? eff - 1 : eff + 1;
      end
    end
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_test();
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset(1'b0);

    // march element: up, write 0
    for (int i = 0; i < DEPTH; i++) run(2'b10, 1'b0, 1'b1);
    // up: read 0 then write 1
    for (int i = 0; i < DEPTH; i++) begin
      run(2'b00, 1'b0, 1'b0);
      run(2'b10, 1'b1, 1'b1);
    end
    // down: read 1 then write 0 (starts at the top, R4)
    for (int i = 0; i < DEPTH; i++) begin
      run(2'b01, 1'b1, 1'b0);
      run(2'b11, 1'b0, 1'b1);
    end
    // down: read 0
    for (int i = 0; i < DEPTH; i++) run(2'b11, 1'b0, 1'b0);
    run(2'b00, 1'b0, 1'b1);
    run(2'b00, 1'b0, 1'b1);
    check("R7 clean memory", fail_total, 0);

    // one stuck bit on every read of an upward sweep
    inj = 8'h01;
    for (int i = 0; i < DEPTH; i++) run(2'b10, 1'b0, 1'b0);
    run(2'b00, 1'b0, 1'b1);
    run(2'b00, 1'b0, 1'b1);
    check("R7 one bit per read", fail_total, DEPTH);
    check("R9 flag set", fail_seen, 1);

    // writes with fully corrupted read data add nothing
    inj = 8'hFF;
    for (int i = 0; i < 10; i++) run(2'b10, 1'b1, 1'b1);
    run(2'b00, 1'b0, 1'b1);
    check("R8 writes ignored", fail_total, DEPTH);
    inj = '0;

    // random steering mixed with random corruption
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] ra;
      ra = 2'($urandom);
      if ($urandom % 8 == 0) inj = WIDTH'($urandom);
      else inj = '0;
      run(ra, 1'($urandom), 1'($urandom));
    end
    inj = '0;

    // saturation
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) run(2'b10, 1'b0, 1'b1);
    inj = 8'hFF;
    for (int i = 0; i < 200; i++) run(2'b10, 1'b0, 1'b0);
    run(2'b00, 1'b0, 1'b1);
    run(2'b00, 1'b0, 1'b1);
    check("R10 saturated", fail_total, MAXC);
    for (int i = 0; i < 20; i++) run(2'b11, 1'b0, 1'b0);
    run(2'b00, 1'b0, 1'b1);
    run(2'b00, 1'b0, 1'b1);
    check("R10 no wrap", fail_total, MAXC);
    inj = '0;

    // reset toward a downward sweep
    do_reset(1'b1);
    run(2'b11, 1'b1, 1'b1);
    run(2'b11, 1'b1, 1'b1);
    check("R2 after reset", mem_addr, DEPTH - 3);

    finish_test();
  end
endmodule